// File: doc/BRIEF.md
# Peripheral Domain Access Checker

This block sits beside a peripheral bus and judges each access before it reaches its target. A small table gives every bus master a 2-bit domain number. A second table holds, for every peripheral, an access-policy word. Each word has a read-enable bit and a write-enable bit for each of the four domains, a semaphore-required flag and a lock bit. An access request names a master, a peripheral and a direction. The block resolves the master's domain, checks the matching permission bit, and one cycle later reports grant or deny. A denied access also produces a violation pulse that carries the offending master and peripheral numbers.

Some peripherals are shared between domains. For these, software sets the semaphore-required flag. An access to such a peripheral is then granted only while the requesting domain holds that peripheral's semaphore gate. The gate owner is supplied on an input.

Both tables are programmed through a simple word-wide register bus and can be read back over it. A lock bit in any entry freezes that entry until reset.

Top module: `periph_domain_guard`

## Requirements
- R1: After reset every master entry and policy word reads back as zero. Every master is therefore in domain 0, and every access is denied.
- R2: A register write with address bit 8 clear targets master entry `regAddr[7:0]`. Bits [1:0] of the data set the domain and bit 31 sets the lock. Reading the entry back returns {lock, 29 zeros, domain}.
- R3: A register write with address bit 8 set targets policy word `regAddr[7:0]`. For domain d, bit 2d enables writes and bit 2d+1 enables reads. Bit 30 is the semaphore-required flag and bit 31 is the lock. Reading the word back returns {lock, flag, 22 zeros, bits[7:0]}.
- R4: Once an entry's lock bit is set, all later writes to that entry are ignored until reset, including writes that would clear the lock.
- R5: A request asserted in one cycle is answered in the next cycle with `respValid` high. A read is granted only if the read bit of the master's domain is set, and a write only if the write bit is set.
- R6: `respSemNeeded` reports the semaphore-required flag of the requested peripheral. When that flag is set, a grant also requires `semOwnerValid` high and `semOwnerDom` equal to the requester's domain.
- R7: Each denied request raises `violValid` for one cycle per denied request, with `violMaster` and `violPeriph` equal to that request's IDs. `violValid` is never high together with `respGrant`.
- R8: A master ID at or beyond the master count is treated as domain 0. A peripheral ID at or beyond the peripheral count is always denied. Writes to out-of-range entries are ignored, and reads from them return zero.
- R9: A table write takes effect for requests from the following cycle on. A request in the same cycle as a write is judged on the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 9 | Bit 8 selects the table, bits [7:0] select the entry |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational readback of the addressed entry |
| reqValid | input | 1 | Access request present |
| reqMaster | input | 8 | Requesting master ID |
| reqPeriph | input | 8 | Target peripheral ID |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| semOwnerValid | input | 1 | The target peripheral's semaphore gate is held |
| semOwnerDom | input | 2 | Domain that holds the gate |
| respValid | output | 1 | Decision for the previous cycle's request |
| respGrant | output | 1 | Access granted |
| respSemNeeded | output | 1 | The target peripheral requires a semaphore |
| violValid | output | 1 | One-cycle pulse per denied access |
| violMaster | output | 8 | Master ID of the denied access |
| violPeriph | output | 8 | Peripheral ID of the denied access |

## Verification
Directed patterns come first. A peripheral that is read-only for one domain separates the read-bit check from the write-bit check. The same peripheral accessed from other domains shows that the domain is found through the master table and not taken from the master number. Semaphore-gated accesses are tried with a matching owner, a wrong owner and no owner, which isolates the extra condition. Writes to locked entries, out-of-range IDs, and a write issued in the same cycle as an access to the same entry each test the edges of table update. A long stretch of random writes, reads and requests then runs against the bench's behavioural model, so that different lock, flag and domain combinations interact.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  localparam int ID_W    = 8;
  localparam int DOM_W   = 2;
  localparam int NUM_DOM = 1 << DOM_W;
  localparam int PERM_W  = 2 * NUM_DOM;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = ID_W + 1;
  localparam int LOCK_BIT = 31;
  localparam int SEM_BIT  = 30;

  // strobes from control to datapath
  typedef struct packed {
    logic            mstWe;
    logic            polWe;
    logic [ID_W-1:0] idx;
  } pdgStrobe_t;
endpackage

// File: rtl/pdg_datapath.sv
module pdg_datapath
  import pdg_pkg::*;
#(
  parameter int NUM_MASTERS = 16,
  parameter int NUM_PERIPHS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pdgStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [ID_W-1:0]   lkMaster,
  input  logic [ID_W-1:0]   lkPeriph,
  output logic [DOM_W-1:0]  lkDom,
  output logic [PERM_W-1:0] lkPerm,
  output logic              lkSem
);
  localparam int MIDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam int PIDX_W = (NUM_PERIPHS > 1) ? $clog2(NUM_PERIPHS) : 1;
  localparam logic [ID_W:0] MST_LIM = (ID_W+1)'(NUM_MASTERS);
  localparam logic [ID_W:0] PER_LIM = (ID_W+1)'(NUM_PERIPHS);

  logic [DOM_W-1:0]  mstDom  [NUM_MASTERS];
  logic              mstLock [NUM_MASTERS];
  logic [PERM_W-1:0] polPerm [NUM_PERIPHS];
  logic              polSem  [NUM_PERIPHS];
  logic              polLock [NUM_PERIPHS];

  logic wrMstHit, wrPolHit;
  assign wrMstHit = ({1'b0, strb.idx} < MST_LIM);
  assign wrPolHit = ({1'b0, strb.idx} < PER_LIM);

  // master table: locked entries ignore writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MASTERS; i++) begin
        mstDom[i]  <= '0;
        mstLock[i] <= 1'b0;
      end
    end else if (strb.mstWe && wrMstHit && !mstLock[strb.idx[MIDX_W-1:0]]) begin
      mstDom[strb.idx[MIDX_W-1:0]]  <= wrData[DOM_W-1:0];
      mstLock[strb.idx[MIDX_W-1:0]] <= wrData[LOCK_BIT];
    end
  end

  // policy table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PERIPHS; i++) begin
        polPerm[i] <= '0;
        polSem[i]  <= 1'b0;
        polLock[i] <= 1'b0;
      end
    end else if (strb.polWe && wrPolHit && !polLock[strb.idx[PIDX_W-1:0]]) begin
      polPerm[strb.idx[PIDX_W-1:0]] <= wrData[PERM_W-1:0];
      polSem[strb.idx[PIDX_W-1:0]]  <= wrData[SEM_BIT];
      polLock[strb.idx[PIDX_W-1:0]] <= wrData[LOCK_BIT];
    end
  end

  // access lookup
  logic lkMstHit, lkPerHit;
  assign lkMstHit = ({1'b0, lkMaster} < MST_LIM);
  assign lkPerHit = ({1'b0, lkPeriph} < PER_LIM);

  always_comb begin
    lkDom  = lkMstHit ? mstDom[lkMaster[MIDX_W-1:0]] : '0;
    lkPerm = lkPerHit ? polPerm[lkPeriph[PIDX_W-1:0]] : '0;
    lkSem  = lkPerHit ? polSem[lkPeriph[PIDX_W-1:0]] : 1'b0;
  end

  // register readback
  logic [ID_W-1:0] rdIdx;
  assign rdIdx = rdAddr[ID_W-1:0];

  always_comb begin
    rdData = '0;
    if (!rdAddr[ID_W]) begin
      if ({1'b0, rdIdx} < MST_LIM) begin
        rdData[DOM_W-1:0] = mstDom[rdIdx[MIDX_W-1:0]];
        rdData[LOCK_BIT]  = mstLock[rdIdx[MIDX_W-1:0]];
      end
    end else begin
      if ({1'b0, rdIdx} < PER_LIM) begin
        rdData[PERM_W-1:0] = polPerm[rdIdx[PIDX_W-1:0]];
        rdData[SEM_BIT]    = polSem[rdIdx[PIDX_W-1:0]];
        rdData[LOCK_BIT]   = polLock[rdIdx[PIDX_W-1:0]];
      end
    end
  end

  // lock stickiness, per entry
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mstChk
    p_mst_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      mstLock[m] |=> (mstLock[m] && $stable(mstDom[m])));
  end
  for (genvar p = 0; p < NUM_PERIPHS; p++) begin : g_polChk
    p_pol_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      polLock[p] |=> (polLock[p] && $stable(polPerm[p]) && $stable(polSem[p])));
  end
endmodule

// File: rtl/pdg_ctrl.sv
module pdg_ctrl
  import pdg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output pdgStrobe_t        strb,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqMaster,
  input  logic [ID_W-1:0]   reqPeriph,
  input  logic              reqWrite,
  input  logic              semOwnerValid,
  input  logic [DOM_W-1:0]  semOwnerDom,
  input  logic [DOM_W-1:0]  lkDom,
  input  logic [PERM_W-1:0] lkPerm,
  input  logic              lkSem,
  output logic              respValid,
  output logic              respGrant,
  output logic              respSemNeeded,
  output logic              violValid,
  output logic [ID_W-1:0]   violMaster,
  output logic [ID_W-1:0]   violPeriph
);
  // register bus decode
  always_comb begin
    strb.mstWe = regWrEn && !regAddr[ID_W];
    strb.polWe = regWrEn &&  regAddr[ID_W];
    strb.idx   = regAddr[ID_W-1:0];
  end

  // decision: write bit at 2d, read bit at 2d+1
  logic [$clog2(PERM_W)-1:0] permSel;
  logic rwOk, semOk, grant;
  assign permSel = {lkDom, ~reqWrite};
  assign rwOk    = lkPerm[permSel];
  assign semOk   = !lkSem || (semOwnerValid && (semOwnerDom == lkDom));
  assign grant   = rwOk && semOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respGrant     <= 1'b0;
      respSemNeeded <= 1'b0;
      violValid     <= 1'b0;
      violMaster    <= '0;
      violPeriph    <= '0;
    end else begin
      respValid     <= reqValid;
      respGrant     <= reqValid && grant;
      respSemNeeded <= reqValid && lkSem;
      violValid     <= reqValid && !grant;
      if (reqValid && !grant) begin
        violMaster <= reqMaster;
        violPeriph <= reqPeriph;
      end
    end
  end

  p_resp_follows_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  p_no_resp_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !violValid && !respGrant));
  p_grant_not_viol_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(respGrant && violValid));
  p_sem_owner_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lkSem && !semOwnerValid) |=> !respGrant);
endmodule

// File: rtl/periph_domain_guard.sv
module periph_domain_guard
  import pdg_pkg::*;
#(
  parameter int NUM_MASTERS = 16,
  parameter int NUM_PERIPHS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [8:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        reqValid,
  input  logic [7:0]  reqMaster,
  input  logic [7:0]  reqPeriph,
  input  logic        reqWrite,
  input  logic        semOwnerValid,
  input  logic [1:0]  semOwnerDom,
  output logic        respValid,
  output logic        respGrant,
  output logic        respSemNeeded,
  output logic        violValid,
  output logic [7:0]  violMaster,
  output logic [7:0]  violPeriph
);
  pdgStrobe_t        strb;
  logic [DOM_W-1:0]  lkDom;
  logic [PERM_W-1:0] lkPerm;
  logic              lkSem;

  pdg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb),
    .reqValid(reqValid), .reqMaster(reqMaster), .reqPeriph(reqPeriph),
    .reqWrite(reqWrite), .semOwnerValid(semOwnerValid), .semOwnerDom(semOwnerDom),
    .lkDom(lkDom), .lkPerm(lkPerm), .lkSem(lkSem),
    .respValid(respValid), .respGrant(respGrant), .respSemNeeded(respSemNeeded),
    .violValid(violValid), .violMaster(violMaster), .violPeriph(violPeriph)
  );

  pdg_datapath #(.NUM_MASTERS(NUM_MASTERS), .NUM_PERIPHS(NUM_PERIPHS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .rdAddr(regAddr), .rdData(regRdData),
    .lkMaster(reqMaster), .lkPeriph(reqPeriph),
    .lkDom(lkDom), .lkPerm(lkPerm), .lkSem(lkSem)
  );
endmodule

// File: tb/periph_domain_guard_tb.sv
`timescale 1ns/1ps
module periph_domain_guard_tb_top;
  localparam int NM = 16;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [8:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic reqValid = 1'b0, reqWrite = 1'b0, semOwnerValid = 1'b0;
  logic [7:0] reqMaster = '0, reqPeriph = '0;
  logic [1:0] semOwnerDom = '0;
  logic respValid, respGrant, respSemNeeded, violValid;
  logic [7:0] violMaster, violPeriph;

  always #4 clk = ~clk;

  periph_domain_guard #(.NUM_MASTERS(NM), .NUM_PERIPHS(NP)) dut_i (.*);

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // behavioural model state
  int mDom[NM];  bit mLock[NM];
  int pBits[NP]; bit pSem[NP]; bit pLock[NP];
  bit eV, eG, eS, eVi;
  int eVm, eVp;

  task automatic chk(input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic longint modelRead(input logic [8:0] a);
    int i = int'(a[7:0]);
    if (!a[8]) return (i < NM) ? ((longint'(mLock[i]) << 31) | mDom[i]) : 0;
    return (i < NP) ? ((longint'(pLock[i]) << 31) | (longint'(pSem[i]) << 30) | pBits[i]) : 0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NM; i++) begin mDom[i] = 0; mLock[i] = 0; end
    for (int i = 0; i < NP; i++) begin pBits[i] = 0; pSem[i] = 0; pLock[i] = 0; end
    eV = 0; eG = 0; eS = 0; eVi = 0; eVm = 0; eVp = 0;
  endtask

  task automatic step(input bit we, input logic [8:0] a, input logic [31:0] wd,
                      input bit v, input int m, input int p, input bit w,
                      input bit sov, input int sod, input string tag);
    int dom, bits; bit sem, rwOk, g;
    @(negedge clk);
    chk($sformatf("%s R5 respValid", tag), respValid, eV);
    chk($sformatf("%s R5 respGrant", tag), respGrant, eG);
    chk($sformatf("%s R6 respSemNeeded", tag), respSemNeeded, eS);
    chk($sformatf("%s R7 violValid", tag), violValid, eVi);
    if (eVi) begin
      chk($sformatf("%s R7 violMaster", tag), violMaster, eVm);
      chk($sformatf("%s R7 violPeriph", tag), violPeriph, eVp);
    end
    regWrEn = we; regAddr = a; regWrData = wd;
    reqValid = v; reqMaster = 8'(m); reqPeriph = 8'(p); reqWrite = w;
    semOwnerValid = sov; semOwnerDom = 2'(sod);
    #1;
    chk($sformatf("%s R2 R3 readback @%0h", tag, a), regRdData, modelRead(a));
    dom  = (m < NM) ? mDom[m] : 0;
    bits = (p < NP) ? pBits[p] : 0;
    sem  = (p < NP) ? pSem[p] : 0;
    rwOk = w ? bits[2*dom] : bits[2*dom+1];
    g    = rwOk && (!sem || (sov && sod == dom));
    eV = v; eG = v && g; eS = v && sem; eVi = v && !g;
    if (v && !g) begin eVm = m; eVp = p; end
    if (we) begin
      int i = int'(a[7:0]);
      if (!a[8] && i < NM && !mLock[i]) begin mDom[i] = int'(wd[1:0]); mLock[i] = wd[31]; end
      if (a[8] && i < NP && !pLock[i]) begin pBits[i] = int'(wd[7:0]); pSem[i] = wd[30]; pLock[i] = wd[31]; end
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input string tag);
    step(1, a, d, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic acc(input int m, input int p, input bit w, input bit sov, input int sod,
                     input string tag);
    step(0, 9'h100 | 9'(p & 8'hff), 0, 1, m, p, w, sov, sod, tag);
  endtask
  task automatic rd(input logic [8:0] a, input string tag);
    step(0, a, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: everything zero, every access denied
    rd(9'h000, "R1"); rd(9'h105, "R1");
    acc(0, 0, 0, 0, 0, "R1"); acc(5, 3, 1, 0, 0, "R1");
    // R2: master domains, one locked
    wr(9'h001, 32'h1, "R2"); wr(9'h002, 32'h2, "R2"); wr(9'h003, 32'h3, "R2");
    wr(9'h004, 32'h8000_0003, "R2"); rd(9'h004, "R2");
    // R3: policy words
    wr(9'h101, 32'h08, "R3");               // read only for domain 1
    wr(9'h102, 32'hFF, "R3");               // all domains read/write
    wr(9'h103, 32'h40, "R3");               // write only for domain 3
    wr(9'h104, 32'h4000_003C, "R3");        // domains 1,2 rw, semaphore
    rd(9'h104, "R3");
    // R5: direction and domain lookup
    acc(1, 1, 0, 0, 0, "R5"); acc(1, 1, 1, 0, 0, "R5"); acc(0, 1, 0, 0, 0, "R5");
    acc(3, 3, 1, 0, 0, "R5"); acc(3, 3, 0, 0, 0, "R5"); acc(2, 1, 0, 0, 0, "R5");
    // R6: semaphore gating
    acc(1, 4, 0, 1, 1, "R6"); acc(1, 4, 0, 1, 2, "R6"); acc(1, 4, 1, 0, 1, "R6");
    acc(2, 4, 1, 1, 2, "R6"); acc(3, 4, 0, 1, 3, "R6");
    // R7: back-to-back denials with distinct IDs
    acc(0, 1, 1, 0, 0, "R7"); acc(9, 7, 0, 0, 0, "R7"); acc(1, 2, 0, 0, 0, "R7");
    // R4: locked entries
    wr(9'h004, 32'h0, "R4"); rd(9'h004, "R4"); acc(4, 3, 1, 0, 0, "R4");
    wr(9'h105, 32'h8000_00FF, "R4"); wr(9'h105, 32'h0, "R4"); rd(9'h105, "R4");
    acc(0, 5, 1, 0, 0, "R4");
    // R8: out-of-range IDs
    acc(200, 2, 0, 0, 0, "R8"); acc(1, 100, 0, 0, 0, "R8");
    wr(9'h0F0, 32'h3, "R8"); rd(9'h0F0, "R8"); wr(9'h1F0, 32'hFF, "R8"); rd(9'h1F0, "R8");
    // R9: same-cycle write and request
    step(1, 9'h106, 32'h3, 1, 0, 6, 0, 0, 0, "R9");
    acc(0, 6, 0, 0, 0, "R9");
    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] wd = $urandom;
      logic [8:0] a;
      wd[31] = ($urandom_range(0, 19) == 0);
      a = {1'($urandom_range(0, 1)), 8'($urandom_range(0, 36))};
      step($urandom_range(0, 3) == 0, a, wd, $urandom_range(0, 3) != 0,
           $urandom_range(0, 19), $urandom_range(0, 35), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 3), "RND");
    end
    rd(9'h000, "END");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule